// File: doc/BRIEF.md
# Pulse-Swallow Divider Controller

This block holds the counters that sit behind a dual-modulus prescaler in a frequency synthesizer's feedback path. It is clocked by the prescaler's output. It holds a swallow count A and a period count B, and it drives a modulus-select line. The line asks the prescaler to divide by P+1 for the first A prescaler cycles of every period and by P for the remaining B−A cycles. Each period spans B prescaler cycles, so it covers P·B + A cycles of the prescaler's input. At the end of each period the block emits a single-cycle pulse, which is the divided-down signal passed on to phase comparison.

A new (A, B) pair is presented with a load strobe. The pair is checked against the limits that keep the swallow scheme working: B at least the minimum, A below B, and A below P. A valid pair is staged and copied into the working registers only when the running period ends. A period therefore never mixes two settings. An invalid pair is refused, the working and staged values stay as they were, and an error flag is raised. The next valid load clears the flag.

Top module: `swallow_div_ctrl`

## Requirements
- R1: Each period lasts exactly B cycles of `pclk`, so a prescaler following `mod_sel` (divide by 65 when high, by 64 when low, with P = 64) consumes 64·B + A input cycles per period.
- R2: `mod_sel` is 1 for the first A cycles of a period and 0 for the remaining B − A cycles. It never rises inside a period.
- R3: `period_pulse` is 1 for exactly one cycle, the last cycle of each period, and 0 in every other cycle.
- R4: With A = 0, `mod_sel` stays 0 for the whole period.
- R5: A valid load changes nothing in the period that is running. The new pair governs the first period that starts after the load edge. A load on the same edge that ends a period waits for the following period.
- R6: A load with B < 3, A ≥ B or A ≥ 64 sets `cfg_err` to 1 one edge later and leaves the division unchanged.
- R7: A valid load sets `cfg_err` back to 0 one edge later.
- R8: During and right after reset, `cfg_err` = 0, `period_pulse` = 0, and a period of the default pair A = 1, B = 4 begins, so `mod_sel` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Strobe: take `cfg_a` and `cfg_b` this edge |
| cfg_a | input | 7 | Swallow count A |
| cfg_b | input | 11 | Period count B |
| mod_sel | output | 1 | 1 = prescaler divides by P+1, 0 = by P |
| period_pulse | output | 1 | One-cycle pulse at the end of each period |
| cfg_err | output | 1 | Last load was refused |

## Verification
`mod_sel` and `period_pulse` are decoded straight from the counter state. They therefore belong to the cycle in which the counters hold that state, and the bench samples them on the falling edge inside that cycle. `cfg_err` follows the rising edge that captures a load, so it is checked at the next falling edge. A new pair shows up only after a period boundary. Because of that, the bench first waits for the pulse that ends the old period and then counts a whole period from the cycle after it. The count covers cycles, `mod_sel` cycles, the order of high and low, and the summed prescaler input cycles. A load that lands exactly on a period's last cycle is checked to produce one more old-value period first.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;
   localparam int SWD_A_W = 7;
   localparam int SWD_B_W = 11;

   typedef struct packed {
      logic [SWD_A_W-1:0] a;
      logic [SWD_B_W-1:0] b;
   } swdiv_pair_t;
endpackage

// File: rtl/swdiv_down_cnt.sv
module swdiv_down_cnt #(
   parameter int W        = 8,
   parameter int RST_VAL  = 0,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         reload_i,
   input  logic [W-1:0] reload_val_i,
   output logic [W-1:0] cnt_o,
   output logic         zero_o
);
   localparam logic [W-1:0] RST_CNT = W'(RST_VAL);

   if (RST_VAL < 0 || RST_VAL >= (1 << W)) begin : g_bad_rst
      $error("swdiv_down_cnt: RST_VAL does not fit in W bits");
   end

   logic [W-1:0] cnt_q;

   if (SATURATE) begin : g_sat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             cnt_q <= RST_CNT;
         else if (reload_i)      cnt_q <= reload_val_i;
         else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      end
   end else begin : g_wrap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             cnt_q <= RST_CNT;
         else if (reload_i)      cnt_q <= reload_val_i;
         else                    cnt_q <= cnt_q - 1'b1;
      end
   end

   assign cnt_o  = cnt_q;
   assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/swdiv_cfg.sv
module swdiv_cfg
   import swdiv_pkg::*;
#(
   parameter int P_MOD = 64,
   parameter int B_MIN = 3,
   parameter int DEF_A = 1,
   parameter int DEF_B = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_i,
   input  logic [SWD_A_W-1:0]  a_i,
   input  logic [SWD_B_W-1:0]  b_i,
   input  logic                boundary_i,
   output swdiv_pair_t         act_o,
   output swdiv_pair_t         nxt_o,
   output logic                err_o
);
   localparam logic [SWD_B_W-1:0] B_LO  = SWD_B_W'(B_MIN);
   localparam logic [SWD_A_W:0]   A_LIM = (SWD_A_W+1)'(P_MOD);
   localparam swdiv_pair_t DEF_PAIR = '{a: SWD_A_W'(DEF_A), b: SWD_B_W'(DEF_B)};

   logic        a_below_p;
   logic        pair_ok;
   swdiv_pair_t act_q, pend_q;
   logic        pend_vld_q, err_q;

   // The modulus check is only needed when the A field can reach P.
   if ((1 << SWD_A_W) > P_MOD) begin : g_a_lim
      assign a_below_p = ({1'b0, a_i} < A_LIM);
   end else begin : g_a_free
      assign a_below_p = 1'b1;
   end

   assign pair_ok = a_below_p && (b_i >= B_LO) && ({4'd0, a_i} < b_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q      <= DEF_PAIR;
         pend_q     <= DEF_PAIR;
         pend_vld_q <= 1'b0;
         err_q      <= 1'b0;
      end else begin
         if (boundary_i && pend_vld_q) act_q <= pend_q;
         if (load_i && pair_ok) begin
            pend_q     <= '{a: a_i, b: b_i};
            pend_vld_q <= 1'b1;
         end else if (boundary_i) begin
            pend_vld_q <= 1'b0;
         end
         if (load_i) err_q <= !pair_ok;
      end
   end

   assign nxt_o = (boundary_i && pend_vld_q) ? pend_q : act_q;
   assign act_o = act_q;
   assign err_o = err_q;

   AST_BAD_LOAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      load_i && !pair_ok |=> err_o);                                    // R6
   AST_BAD_LOAD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      load_i && !pair_ok |=> $stable(pend_q));                          // R6
   AST_GOOD_LOAD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      load_i && pair_ok |=> !err_o);                                    // R7
endmodule

// File: rtl/swallow_div_ctrl.sv
module swallow_div_ctrl
   import swdiv_pkg::*;
#(
   parameter int P_MOD = 64,
   parameter int B_MIN = 3,
   parameter int DEF_A = 1,
   parameter int DEF_B = 4
) (
   input  logic               pclk,
   input  logic               rst_n,
   input  logic               cfg_load,
   input  logic [SWD_A_W-1:0] cfg_a,
   input  logic [SWD_B_W-1:0] cfg_b,
   output logic               mod_sel,
   output logic               period_pulse,
   output logic               cfg_err
);
   if (P_MOD < 2)                       begin : g_bad_p   $error("P_MOD below 2");            end
   if (B_MIN < 2)                       begin : g_bad_min $error("B_MIN below 2");            end
   if (DEF_B < B_MIN || DEF_B >= (1 << SWD_B_W))
                                        begin : g_bad_db  $error("DEF_B out of range");       end
   if (DEF_A < 0 || DEF_A >= DEF_B || DEF_A >= P_MOD)
                                        begin : g_bad_da  $error("DEF_A out of range");       end

   swdiv_pair_t act, nxt;
   logic        b_zero, a_zero, boundary;
   logic [SWD_B_W-1:0] b_cnt;
   logic [SWD_A_W-1:0] a_cnt;

   assign boundary = b_zero;

   swdiv_cfg #(.P_MOD(P_MOD), .B_MIN(B_MIN), .DEF_A(DEF_A), .DEF_B(DEF_B)) u_cfg (
      .clk(pclk), .rst_n(rst_n), .load_i(cfg_load), .a_i(cfg_a), .b_i(cfg_b),
      .boundary_i(boundary), .act_o(act), .nxt_o(nxt), .err_o(cfg_err)
   );

   // Period counter: B-1 down to 0, reload on zero.
   swdiv_down_cnt #(.W(SWD_B_W), .RST_VAL(DEF_B - 1), .SATURATE(1'b0)) u_bcnt (
      .clk(pclk), .rst_n(rst_n), .reload_i(boundary), .reload_val_i(nxt.b - 1'b1),
      .cnt_o(b_cnt), .zero_o(b_zero)
   );

   // Swallow counter: A down to 0, holds at 0 until the next period.
   swdiv_down_cnt #(.W(SWD_A_W), .RST_VAL(DEF_A), .SATURATE(1'b1)) u_acnt (
      .clk(pclk), .rst_n(rst_n), .reload_i(boundary), .reload_val_i(nxt.a),
      .cnt_o(a_cnt), .zero_o(a_zero)
   );

   assign mod_sel      = !a_zero;
   assign period_pulse = b_zero;

   AST_PULSE_SINGLE: assert property (@(posedge pclk) disable iff (!rst_n)
      period_pulse |=> !period_pulse);                                  // R3
   AST_MOD_NO_RISE: assert property (@(posedge pclk) disable iff (!rst_n)
      !mod_sel && !period_pulse |=> !mod_sel);                          // R2
   AST_MOD_LOW_AT_END: assert property (@(posedge pclk) disable iff (!rst_n)
      period_pulse |-> !mod_sel);                                       // R2
   AST_ACT_STABLE: assert property (@(posedge pclk) disable iff (!rst_n)
      !period_pulse |=> $stable(act));                                  // R5
   AST_ACT_VALID: assert property (@(posedge pclk) disable iff (!rst_n)
      act.b >= SWD_B_W'(B_MIN) && {4'd0, act.a} < act.b);               // R6
   AST_CNT_BOUND: assert property (@(posedge pclk) disable iff (!rst_n)
      b_cnt < act.b);                                                   // R1
endmodule

// File: tb/swallow_div_ctrl_bench.sv
module swallow_div_ctrl_bench;
   logic        pclk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_load = 1'b0;
   logic [6:0]  cfg_a = '0;
   logic [10:0] cfg_b = '0;
   logic        mod_sel, period_pulse, cfg_err;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #2 pclk = ~pclk;

   swallow_div_ctrl u_swallow_div_ctrl (
      .pclk(pclk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_a(cfg_a), .cfg_b(cfg_b),
      .mod_sel(mod_sel), .period_pulse(period_pulse), .cfg_err(cfg_err)
   );

   always @(posedge pclk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_pulse();
      for (int k = 0; k < 5000; k++) begin
         @(negedge pclk);
         if (period_pulse) break;
      end
   endtask

   // Counts one period starting at the current (now=1) or next falling edge.
   task automatic measure(input bit now, output int ncyc, output int nhi,
                          output int nin, output bit order_ok);
      bit seen_low;
      ncyc = 0; nhi = 0; nin = 0; order_ok = 1'b1; seen_low = 1'b0;
      for (int k = 0; k < 5000; k++) begin
         if (k > 0 || !now) @(negedge pclk);
         ncyc++;
         nin += mod_sel ? 65 : 64;
         if (mod_sel) begin
            nhi++;
            if (seen_low) order_ok = 1'b0;
         end else seen_low = 1'b1;
         if (period_pulse) break;
      end
   endtask

   task automatic check_period(input bit now, input int ea, input int eb, input string tag);
      int c, h, n; bit o;
      measure(now, c, h, n, o);
      chk(c == eb, {tag, " R1 cycles"}, c, eb);
      chk(h == ea, {tag, " R2 mod_sel count"}, h, ea);
      chk(o, {tag, " R2 high-then-low order"}, o, 1);
      chk(n == 64 * eb + ea, {tag, " R1 input cycles"}, n, 64 * eb + ea);
   endtask

   task automatic do_load(input int a, input int b);
      @(negedge pclk);
      cfg_a = 7'(a); cfg_b = 11'(b); cfg_load = 1'b1;
      @(negedge pclk);
      cfg_load = 1'b0;
   endtask

   // {b, a}
   localparam logic [17:0] VEC [6] = '{
      {11'd3,    7'd0},
      {11'd3,    7'd2},
      {11'd100,  7'd63},
      {11'd2047, 7'd5},
      {11'd11,   7'd10},
      {11'd64,   7'd0}
   };

   initial begin
      int c, h, n; bit o;
      // R8 reset state
      repeat (3) @(negedge pclk);
      chk(cfg_err == 1'b0, "R8 cfg_err in reset", cfg_err, 0);
      chk(period_pulse == 1'b0, "R8 pulse in reset", period_pulse, 0);
      chk(mod_sel == 1'b1, "R8 mod_sel in reset", mod_sel, 1);
      rst_n = 1'b1;
      check_period(1'b1, 1, 4, "R8 default period");

      // Table walk: R1 R2 R3 R4
      for (int i = 0; i < 6; i++) begin
         int va, vb;
         va = int'(VEC[i][6:0]);
         vb = int'(VEC[i][17:7]);
         do_load(va, vb);
         chk(cfg_err == 1'b0, "R7 valid load no error", cfg_err, 0);
         wait_pulse();
         check_period(1'b0, va, vb, $sformatf("vec%0d", i));
         // R3 pulse just seen; next cycle must be low
         @(negedge pclk);
         chk(period_pulse == 1'b0, "R3 pulse one cycle", period_pulse, 0);
         if (va == 0) begin
            measure(1'b1, c, h, n, o);
            chk(h == 0, "R4 A=0 keeps mod_sel low", h, 0);
         end
      end

      // R5 load in the middle of a period: running period unchanged
      do_load(5, 20);
      wait_pulse();
      check_period(1'b0, 5, 20, "R5 base");
      begin
         int nc, nh, seen;
         nc = 0; nh = 0;
         for (int k = 0; k < 5000; k++) begin
            @(negedge pclk);
            nc++;
            if (mod_sel) nh++;
            if (k == 1) begin cfg_a = 7'd7; cfg_b = 11'd9; cfg_load = 1'b1; end
            if (k == 2) cfg_load = 1'b0;
            if (period_pulse) break;
         end
         chk(nc == 20, "R5 mid-period load keeps length", nc, 20);
         chk(nh == 5, "R5 mid-period load keeps swallow", nh, 5);
         check_period(1'b0, 7, 9, "R5 new pair next period");
      end

      // R5 load coincident with the period-end cycle
      wait_pulse();
      cfg_a = 7'd3; cfg_b = 11'd6; cfg_load = 1'b1;
      @(negedge pclk);
      cfg_load = 1'b0;
      check_period(1'b1, 7, 9, "R5 coincident load waits");
      check_period(1'b0, 3, 6, "R5 coincident load applied");

      // R6 invalid loads
      do_load(0, 2);
      chk(cfg_err == 1'b1, "R6 B<3 flagged", cfg_err, 1);
      wait_pulse();
      check_period(1'b0, 3, 6, "R6 B<3 kept");
      do_load(5, 5);
      chk(cfg_err == 1'b1, "R6 A>=B flagged", cfg_err, 1);
      wait_pulse();
      check_period(1'b0, 3, 6, "R6 A>=B kept");
      do_load(64, 100);
      chk(cfg_err == 1'b1, "R6 A>=P flagged", cfg_err, 1);
      wait_pulse();
      check_period(1'b0, 3, 6, "R6 A>=P kept");

      // R7 recovery
      do_load(1, 3);
      chk(cfg_err == 1'b0, "R7 valid load clears error", cfg_err, 1'b0);
      wait_pulse();
      check_period(1'b0, 1, 3, "R7 new pair");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule